// File: doc/BRIEF.md
# Linear CCD Sensor Timing Generator

This block derives every drive signal a linear CCD image sensor needs from one fast system clock. It divides the system clock down to the sensor master clock. It produces an active-high shift gate pulse train, whose period sets the integration time. It also produces an active-low integration clear gate that opens each readout frame. For the capture side it provides an ADC sample clock phase-locked to the pixel output (one pixel every four master clocks), a pixel-valid level and a frame-start flag.

All gate timing is counted in master clock periods. The frame length is the shift gate period times a whole-number multiple, so a shift gate pulse always falls inside the clear gate window. Between frames the shift gate runs freely at its own period. Its position relative to the clear gate only matters on the first period of each frame. The configuration inputs are copied into an active set at the first master tick of each frame, so a frame already in progress keeps its timing.

With a 56 MHz system clock and the default divide of 40, the master clock is 1.4 MHz. A shift gate period of 560 master clocks with a multiple of 100 then gives 400 µs integration and 40 ms frames.

Top module: `ccd_timing_gen`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs go to their idle values: `icgGateN`=1 and `mclk`, `shGate`, `adcClk`, `pixValid`, `frameStart`=0. All counters return to zero.
- R2: Every output is registered and reflects the internal state one system clock later. `mclk` has a period of `MCLK_DIV` system clocks and is high for the first `MCLK_DIV/2` of them.
- R3: A frame lasts `shPer*mult` master periods, where `shPer` is the active `cfgShPeriod` and `mult` is the active `cfgIcgMult`. `frameStart` is high for the first master period of each frame. The first frame begins at the first master tick after reset. `cfgShPeriod` must exceed lead+width+trail.
- R4: In every shift gate period, `shGate` is high for `width` master periods, starting `lead` master periods after the period begins. This holds in every period of the frame.
- R5: `icgGateN` is low from the start of each frame for `lead+width+trail` master periods. It therefore falls `lead` periods before `shGate` rises and rises `trail` periods after `shGate` falls. It stays high for the rest of the frame.
- R6: From the `icgGateN` rising edge until the frame ends, `adcClk` runs with a period of 4 master periods. It is high for 2 of them, starting at pixel-group phase `cfgAdcPhase` (0..3, where phase 0 is the first master period after the rise). Before that rising edge `adcClk` is low.
- R7: `pixValid` is high for one master period, at phase `cfgAdcPhase` of each 4-period pixel group after the `icgGateN` rise, for the first `cfgPixCount` groups of the frame only. It is never high while `icgGateN` is low.
- R8: Configuration inputs are sampled only at the master tick that starts a frame. A change made mid-frame first affects the next frame.
- R9: At sampling, a width below `MIN_SH_W` becomes `MIN_SH_W`, a lead or trail of 0 becomes 1, and a multiple of 0 becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgShPeriod | input | PER_W | Shift gate period in master clocks |
| cfgIcgMult | input | MULT_W | Frame length as a multiple of the shift gate period |
| cfgShWidth | input | WID_W | Shift gate high time in master clocks |
| cfgIcgLead | input | WID_W | Clear gate fall to shift gate rise, master clocks |
| cfgIcgTrail | input | WID_W | Shift gate fall to clear gate rise, master clocks |
| cfgAdcPhase | input | 2 | ADC clock rising phase inside a pixel group |
| cfgPixCount | input | PIX_W | Pixel groups flagged valid per frame |
| mclk | output | 1 | Sensor master clock |
| shGate | output | 1 | Shift gate, active high |
| icgGateN | output | 1 | Integration clear gate, active low |
| adcClk | output | 1 | ADC sample clock |
| pixValid | output | 1 | Pixel-valid level, one master period per pixel |
| frameStart | output | 1 | High in the first master period of a frame |

## Verification
The first configuration uses a three-period frame with a pixel count that ends well before the frame does. It separates a valid window bounded by the count from one bounded by the frame, and shows the shift gate repeating outside the clear gate. A second set is applied mid-frame with zero width, a count larger than the frame holds and the last ADC phase. It tells sampling at the frame boundary apart from immediate use, and shows the clamp and the phase wrap of the ADC clock. A third set with zero lead, trail and multiple checks the single-period frame and the lower clamps. A reset in mid-run shows the idle state and the restart with an aligned gate pair.

// File: rtl/ccd_timing_pkg.sv
package ccd_timing_pkg;

  // Strobes and levels passed from the sequencing control to the datapath.
  typedef struct packed {
    logic tick;       // last system clock of a master period
    logic mclkHigh;   // master clock high half
    logic frameNew;   // tick on which a new frame begins
    logic frameHead;  // state is in the first master period of a frame
    logic shLevel;    // shift gate level for the current master period
    logic icgLow;     // clear gate asserted for the current master period
    logic pixStart;   // tick after which pixel counting begins
  } ctrlStrobe_t;

endpackage

// File: rtl/ccdSeqCtrl.sv
module ccdSeqCtrl
  import ccd_timing_pkg::*;
#(
  parameter int MCLK_DIV = 40,
  parameter int PER_W    = 16,
  parameter int MULT_W   = 8,
  parameter int WID_W    = 8,
  parameter int PIX_W    = 12,
  parameter int MIN_SH_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PER_W-1:0]  cfgShPeriod,
  input  logic [MULT_W-1:0] cfgIcgMult,
  input  logic [WID_W-1:0]  cfgShWidth,
  input  logic [WID_W-1:0]  cfgIcgLead,
  input  logic [WID_W-1:0]  cfgIcgTrail,
  input  logic [1:0]        cfgAdcPhase,
  input  logic [PIX_W-1:0]  cfgPixCount,
  output ctrlStrobe_t       st,
  output logic [1:0]        actPhase,
  output logic [PIX_W-1:0]  actPixCount
);

  localparam int DIV_W = $clog2(MCLK_DIV);
  localparam int HALF  = MCLK_DIV / 2;

  // master clock divider
  logic [DIV_W-1:0] divCnt;
  logic             tick;
  assign tick = (divCnt == DIV_W'(MCLK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst)       divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + 1'b1;
  end

  // clamped values taken at the frame boundary
  logic [WID_W-1:0]  nextWidth, nextLead, nextTrail;
  logic [MULT_W-1:0] nextMult;

  always_comb begin
    nextWidth = (cfgShWidth < WID_W'(MIN_SH_W)) ? WID_W'(MIN_SH_W) : cfgShWidth;
    nextLead  = (cfgIcgLead  == '0) ? WID_W'(1) : cfgIcgLead;
    nextTrail = (cfgIcgTrail == '0) ? WID_W'(1) : cfgIcgTrail;
    nextMult  = (cfgIcgMult  == '0) ? MULT_W'(1) : cfgIcgMult;
  end

  // active frame configuration
  logic [PER_W-1:0]  aShPer;
  logic [MULT_W-1:0] aMult;
  logic [WID_W-1:0]  aWidth, aLead, aTrail;

  // frame position
  logic              running;
  logic [PER_W-1:0]  shCnt;
  logic [MULT_W-1:0] slot;

  logic [PER_W-1:0]  shEnd, icgSpan;
  logic              lastTick, lastSlot, frameEnd, firstSlot;

  assign shEnd     = PER_W'(aLead) + PER_W'(aWidth);
  assign icgSpan   = shEnd + PER_W'(aTrail);
  assign lastTick  = (shCnt == aShPer - PER_W'(1));
  assign lastSlot  = (slot == aMult - MULT_W'(1));
  assign frameEnd  = !running || (lastTick && lastSlot);
  assign firstSlot = (slot == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      running     <= 1'b0;
      shCnt       <= '0;
      slot        <= '0;
      aShPer      <= '0;
      aMult       <= '0;
      aWidth      <= '0;
      aLead       <= '0;
      aTrail      <= '0;
      actPhase    <= '0;
      actPixCount <= '0;
    end else if (tick) begin
      if (frameEnd) begin
        // R8: configuration only sampled here
        aShPer      <= cfgShPeriod;
        aMult       <= nextMult;
        aWidth      <= nextWidth;
        aLead       <= nextLead;
        aTrail      <= nextTrail;
        actPhase    <= cfgAdcPhase;
        actPixCount <= cfgPixCount;
        running     <= 1'b1;
        shCnt       <= '0;
        slot        <= '0;
      end else if (lastTick) begin
        shCnt <= '0;
        slot  <= slot + 1'b1;
      end else begin
        shCnt <= shCnt + 1'b1;
      end
    end
  end

  logic shOnNow, icgLowNow;
  assign shOnNow   = running && (shCnt >= PER_W'(aLead)) && (shCnt < shEnd);
  assign icgLowNow = running && firstSlot && (shCnt < icgSpan);

  always_comb begin
    st.tick      = tick;
    st.mclkHigh  = (divCnt < DIV_W'(HALF));
    st.frameNew  = tick && frameEnd;
    st.frameHead = running && firstSlot && (shCnt == '0);
    st.shLevel   = shOnNow;
    st.icgLow    = icgLowNow;
    st.pixStart  = tick && !frameEnd && firstSlot && (shCnt == icgSpan - PER_W'(1));
  end

  // R3
  shcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    running |-> (shCnt < aShPer));

  // R3
  frame_restart_chk: assert property (@(posedge clk) disable iff (rst)
    st.frameNew |=> (running && shCnt == '0 && slot == '0));

  // R5
  sh_inside_icg_chk: assert property (@(posedge clk) disable iff (rst)
    (shOnNow && firstSlot) |-> icgLowNow);

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (running && !st.frameNew) |=> $stable(aShPer) && $stable(aMult) && $stable(actPixCount));

endmodule

// File: rtl/ccdPixelPath.sv
module ccdPixelPath
  import ccd_timing_pkg::*;
#(
  parameter int PIX_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobe_t      st,
  input  logic [1:0]       actPhase,
  input  logic [PIX_W-1:0] actPixCount,
  output logic             mclkQ,
  output logic             shQ,
  output logic             icgNQ,
  output logic             adcClkQ,
  output logic             pixValidQ,
  output logic             frameStartQ
);

  logic             pixArm;
  logic [1:0]       pixPh;
  logic [PIX_W-1:0] elemCnt;
  logic [1:0]       relPh;

  assign relPh = pixPh - actPhase;

  // pixel group position after the clear gate opens
  always_ff @(posedge clk) begin
    if (rst) begin
      pixArm  <= 1'b0;
      pixPh   <= '0;
      elemCnt <= '0;
    end else if (st.frameNew) begin
      pixArm  <= 1'b0;
      pixPh   <= '0;
      elemCnt <= '0;
    end else if (st.pixStart) begin
      pixArm  <= 1'b1;
      pixPh   <= '0;
      elemCnt <= '0;
    end else if (st.tick && pixArm) begin
      pixPh <= pixPh + 1'b1;
      if (pixPh == 2'd3 && elemCnt < actPixCount)
        elemCnt <= elemCnt + 1'b1;
    end
  end

  // registered outputs, one system clock behind the state
  always_ff @(posedge clk) begin
    if (rst) begin
      mclkQ       <= 1'b0;
      shQ         <= 1'b0;
      icgNQ       <= 1'b1;
      adcClkQ     <= 1'b0;
      pixValidQ   <= 1'b0;
      frameStartQ <= 1'b0;
    end else begin
      mclkQ       <= st.mclkHigh;
      shQ         <= st.shLevel;
      icgNQ       <= !st.icgLow;
      adcClkQ     <= pixArm && (relPh < 2'd2);
      pixValidQ   <= pixArm && (pixPh == actPhase) && (elemCnt < actPixCount);
      frameStartQ <= st.frameHead;
    end
  end

  // R7
  valid_outside_icg_chk: assert property (@(posedge clk) disable iff (rst)
    pixValidQ |-> icgNQ);

  // R7
  elem_bound_chk: assert property (@(posedge clk) disable iff (rst)
    elemCnt <= actPixCount);

  // R5
  icg_fall_frame_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(icgNQ) |-> frameStartQ);

  // R6
  adc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !icgNQ |-> !adcClkQ);

endmodule

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen
  import ccd_timing_pkg::*;
#(
  parameter int MCLK_DIV = 40,
  parameter int PER_W    = 16,
  parameter int MULT_W   = 8,
  parameter int WID_W    = 8,
  parameter int PIX_W    = 12,
  parameter int MIN_SH_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PER_W-1:0]  cfgShPeriod,
  input  logic [MULT_W-1:0] cfgIcgMult,
  input  logic [WID_W-1:0]  cfgShWidth,
  input  logic [WID_W-1:0]  cfgIcgLead,
  input  logic [WID_W-1:0]  cfgIcgTrail,
  input  logic [1:0]        cfgAdcPhase,
  input  logic [PIX_W-1:0]  cfgPixCount,
  output logic              mclk,
  output logic              shGate,
  output logic              icgGateN,
  output logic              adcClk,
  output logic              pixValid,
  output logic              frameStart
);

  ctrlStrobe_t      st;
  logic [1:0]       actPhase;
  logic [PIX_W-1:0] actPixCount;

  ccdSeqCtrl #(
    .MCLK_DIV(MCLK_DIV), .PER_W(PER_W), .MULT_W(MULT_W),
    .WID_W(WID_W), .PIX_W(PIX_W), .MIN_SH_W(MIN_SH_W)
  ) uCtrl (
    .clk(clk), .rst(rst),
    .cfgShPeriod(cfgShPeriod), .cfgIcgMult(cfgIcgMult),
    .cfgShWidth(cfgShWidth), .cfgIcgLead(cfgIcgLead),
    .cfgIcgTrail(cfgIcgTrail), .cfgAdcPhase(cfgAdcPhase),
    .cfgPixCount(cfgPixCount),
    .st(st), .actPhase(actPhase), .actPixCount(actPixCount)
  );

  ccdPixelPath #(.PIX_W(PIX_W)) uPath (
    .clk(clk), .rst(rst), .st(st),
    .actPhase(actPhase), .actPixCount(actPixCount),
    .mclkQ(mclk), .shQ(shGate), .icgNQ(icgGateN),
    .adcClkQ(adcClk), .pixValidQ(pixValid), .frameStartQ(frameStart)
  );

endmodule

// File: tb/sim_ccd_timing_gen.sv
module sim_ccd_timing_gen;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int MIN_W      = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cfgShPeriod;
  logic [7:0]  cfgIcgMult, cfgShWidth, cfgIcgLead, cfgIcgTrail;
  logic [1:0]  cfgAdcPhase;
  logic [11:0] cfgPixCount;
  logic        mclk, shGate, icgGateN, adcClk, pixValid, frameStart;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccd_timing_gen #(.MCLK_DIV(DIV), .MIN_SH_W(MIN_W)) u0 (
    .clk(clk), .rst(rst),
    .cfgShPeriod(cfgShPeriod), .cfgIcgMult(cfgIcgMult),
    .cfgShWidth(cfgShWidth), .cfgIcgLead(cfgIcgLead),
    .cfgIcgTrail(cfgIcgTrail), .cfgAdcPhase(cfgAdcPhase),
    .cfgPixCount(cfgPixCount),
    .mclk(mclk), .shGate(shGate), .icgGateN(icgGateN),
    .adcClk(adcClk), .pixValid(pixValid), .frameStart(frameStart)
  );

  int checkN = 0;
  int failN  = 0;
  int cyc    = 0;

  task automatic check(input string req, input int act, input int exp);
    checkN++;
    if (act != exp) begin
      failN++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // behavioural reference: frame position counted in master ticks
  int mD = 0, mF = 0, rr = 0, pp = 0, sp = 0;
  bit mRun = 0, modelOn = 0;
  int aPer = 0, aMult = 0, aLead = 0, aW = 0, aTr = 0, aPh = 0, aPix = 0;
  bit eM = 0, eSh = 0, eIcg = 1, eFs = 0, eAdc = 0, ePv = 0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      mD = 0; mF = 0; mRun = 0; modelOn = 1;
      eM = 0; eSh = 0; eIcg = 1; eFs = 0; eAdc = 0; ePv = 0;
    end else begin
      eM = (mD < DIV/2);
      eSh = 0; eIcg = 1; eFs = 0; eAdc = 0; ePv = 0;
      if (mRun) begin
        rr   = aLead + aW + aTr;
        sp   = mF % aPer;
        eSh  = (sp >= aLead) && (sp < aLead + aW);
        eIcg = !(mF < rr);
        eFs  = (mF == 0);
        pp   = mF - rr;
        if (pp >= 0) begin
          eAdc = (((pp % 4) - aPh + 4) % 4) < 2;
          ePv  = ((pp % 4) == aPh) && ((pp / 4) < aPix);
        end
      end
      if (mD == DIV - 1) begin
        mD = 0;
        if (!mRun || mF == aPer * aMult - 1) begin
          aPer  = int'(cfgShPeriod);
          aMult = (cfgIcgMult == 0) ? 1 : int'(cfgIcgMult);
          aW    = (int'(cfgShWidth) < MIN_W) ? MIN_W : int'(cfgShWidth);
          aLead = (cfgIcgLead == 0) ? 1 : int'(cfgIcgLead);
          aTr   = (cfgIcgTrail == 0) ? 1 : int'(cfgIcgTrail);
          aPh   = int'(cfgAdcPhase);
          aPix  = int'(cfgPixCount);
          mF = 0; mRun = 1;
        end else begin
          mF++;
        end
      end else begin
        mD++;
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (modelOn && !rst) begin
      check("R2 mclk",       int'(mclk),       int'(eM));
      check("R4 shGate",     int'(shGate),     int'(eSh));
      check("R5 icgGateN",   int'(icgGateN),   int'(eIcg));
      check("R3 frameStart", int'(frameStart), int'(eFs));
      check("R6 adcClk",     int'(adcClk),     int'(eAdc));
      check("R7 pixValid",   int'(pixValid),   int'(ePv));
    end
  end

  task automatic waitFrameRise(output int when);
    logic last;
    bit   seen;
    last = frameStart;
    seen = 0;
    while (!seen) begin
      @(negedge clk);
      if (frameStart && !last) seen = 1;
      last = frameStart;
    end
    when = cyc;
  endtask

  task automatic highRun(input bit useSh, output int len);
    len = 0;
    if (useSh) while (!shGate) @(negedge clk);
    else       while (icgGateN) @(negedge clk);
    while (useSh ? shGate : !icgGateN) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic checkIdle(input string tag);
    check({tag, " icgGateN idle"}, int'(icgGateN), 1);
    check({tag, " shGate idle"},   int'(shGate),   0);
    check({tag, " mclk idle"},     int'(mclk),     0);
    check({tag, " adcClk idle"},   int'(adcClk),   0);
    check({tag, " pixValid idle"}, int'(pixValid), 0);
    check({tag, " frameStart idle"}, int'(frameStart), 0);
  endtask

  initial begin
    int t0, t1, t2, len;
    // set A: three SH periods per frame, pixel count ends before the frame
    cfgShPeriod = 16'd20; cfgIcgMult = 8'd3; cfgShWidth = 8'd3;
    cfgIcgLead = 8'd2; cfgIcgTrail = 8'd2; cfgAdcPhase = 2'd1; cfgPixCount = 12'd8;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    checkIdle("R1");
    rst = 1'b0;
    repeat (500) @(negedge clk);

    // R8: change mid-frame, the running frame keeps the old length
    waitFrameRise(t0);
    repeat (40) @(negedge clk);
    cfgShPeriod = 16'd16; cfgIcgMult = 8'd2; cfgShWidth = 8'd0;
    cfgIcgLead = 8'd1; cfgIcgTrail = 8'd3; cfgAdcPhase = 2'd3; cfgPixCount = 12'd40;
    waitFrameRise(t1);
    check("R8 frame length before new set", t1 - t0, 20*3*DIV);
    waitFrameRise(t2);
    check("R3 frame length set B", t2 - t1, 16*2*DIV);
    highRun(1'b1, len);
    check("R9 width clamp shGate high cycles", len, MIN_W*DIV);
    repeat (300) @(negedge clk);

    // set C: zero multiple, lead and trail take the lower clamp
    cfgShPeriod = 16'd24; cfgIcgMult = 8'd0; cfgShWidth = 8'd4;
    cfgIcgLead = 8'd0; cfgIcgTrail = 8'd0; cfgAdcPhase = 2'd0; cfgPixCount = 12'd2;
    waitFrameRise(t0);
    waitFrameRise(t1);
    check("R9 multiple clamp frame length", t1 - t0, 24*DIV);
    highRun(1'b0, len);
    check("R5 R9 icgGateN low cycles", len, (1+4+1)*DIV);
    repeat (400) @(negedge clk);

    // reset in mid-run, then restart with set A
    cfgShPeriod = 16'd20; cfgIcgMult = 8'd3; cfgShWidth = 8'd3;
    cfgIcgLead = 8'd2; cfgIcgTrail = 8'd2; cfgAdcPhase = 2'd2; cfgPixCount = 12'd5;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    checkIdle("R1 mid-run");
    rst = 1'b0;
    repeat (600) @(negedge clk);

    $display("%0d/%0d checks passed", checkN - failN, checkN);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checkN++;
    failN++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("%0d/%0d checks passed", checkN - failN, checkN);
    $finish;
  end

endmodule